// File: doc/BRIEF.md
# Per-Domain Access Permission Checker

This block judges every translated memory access against a table of sixteen permission domains. A matched page entry supplies a 4-bit domain index. The requesting master (0 to 5) and the direction, read or write, arrive together with that index on a single-cycle strobe. One cycle later the block reports whether the access is allowed. When the access is refused, it also raises a one-hot violation flag at the position of the offending master, for a downstream fault unit to pick up.

The table is held in 32-bit registers behind a simple write and read port. Each register carries two domains in its two 16-bit halves. Each half holds a pair of deny bits for every master, one for reads and one for writes. After reset every domain allows everything except domain 0. Domain 0 is the default domain, and it refuses writes from all masters, so it is effectively read-only.

The result stage is a three-state machine. RES_IDLE means no result is pending. RES_GRANT and RES_DENY each present one result for one cycle. Every state moves in the next cycle: to RES_GRANT when a strobed access is allowed, to RES_DENY when a strobed access is refused, and to RES_IDLE when no access is strobed.

Top module: `perm_domain_checker`

## Requirements
- R1: After reset the register at address 0x0B0 reads 0x00000AAA and the registers at 0x0B4 through 0x0CC read 0.
- R2: Domain d is held in the register at address 0x0B0 + (d/2)*4. Within that register, the read-deny bit of master m is bit (d%2)*16 + 2*m and the write-deny bit is the bit one above it.
- R3: Bits 12 to 15 and 28 to 31 of every table register always read 0. A write to an address outside 0x0B0..0x0CC, or to an address whose two low bits are not 00, changes nothing. A read of such an address returns 0.
- R4: A read is granted exactly when its read-deny bit is 0, and a write is granted exactly when its write-deny bit is 0.
- R5: res_valid is 1 in the cycle after each cycle in which acc_valid is 1 and is 0 otherwise. res_grant is 1 only while res_valid is 1.
- R6: A refused access from master m (m < 6) sets only bit m of res_viol, for the one cycle in which its result is presented. A granted access, and any cycle without a result, gives res_viol = 0.
- R7: An access from master number 6 or 7 is always refused and raises no violation bit.
- R8: After reset, domain 0 grants reads and refuses writes for every master.
- R9: An access strobed in the same cycle as a table write is judged against the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Table register write enable |
| cfg_addr | input | 12 | Byte address of the table register |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Contents of the addressed register (combinational) |
| acc_valid | input | 1 | Access strobe |
| acc_domain | input | 4 | Domain index taken from the page entry |
| acc_master | input | 3 | Requesting master number |
| acc_write | input | 1 | 1 for a write access, 0 for a read access |
| res_valid | output | 1 | A result is presented this cycle |
| res_grant | output | 1 | The presented access is allowed |
| res_viol | output | 6 | One-hot violation flag, indexed by master |

## Verification
The assertions check the cycle-level shape of the result on every cycle. res_valid follows the strobe by exactly one cycle, res_grant never appears without res_valid, and res_viol is at most one-hot and appears only on a refusal. The same checks confirm that a refusal from a master numbered 0 to 5 always raises a flag and that a refusal from master 6 or 7 never does. Whether a given domain, master and direction should be allowed at all can only be shown by the bench's scenarios. These cover the reset contents, the bit layout across all sixteen domains, the ignored and misaligned addresses, and the ordering between a table write and an access in the same cycle.

// File: rtl/perm_pkg.sv
package perm_pkg;
    typedef enum logic [1:0] {
        RES_IDLE  = 2'd0,
        RES_GRANT = 2'd1,
        RES_DENY  = 2'd2
    } res_state_e;

    localparam int DOMS_PER_REG = 2;
endpackage

// File: rtl/perm_table.sv
module perm_table #(
    parameter int NUM_DOMAINS = 16,
    parameter int NUM_MASTERS = 6,
    parameter int REG_W       = 32,
    parameter int ADDR_W      = 12,
    parameter int BASE_ADDR   = 'hB0
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cfg_wr,
    input  logic [ADDR_W-1:0]                      cfg_addr,
    input  logic [REG_W-1:0]                       cfg_wdata,
    output logic [REG_W-1:0]                       cfg_rdata,
    output logic [NUM_DOMAINS/2-1:0][REG_W-1:0]    table_q
);
    localparam int NUM_REGS = NUM_DOMAINS / perm_pkg::DOMS_PER_REG;
    localparam int SLOT_W   = REG_W / perm_pkg::DOMS_PER_REG;
    localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_REGS * 4);

    // Bits that exist: two per master in each slot.
    function automatic logic [REG_W-1:0] impl_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int s = 0; s < perm_pkg::DOMS_PER_REG; s++)
            for (int b = 0; b < 2 * NUM_MASTERS; b++)
                m[s * SLOT_W + b] = 1'b1;
        return m;
    endfunction

    // Default domain: write-deny set for every master.
    function automatic logic [REG_W-1:0] dom0_reset();
        logic [REG_W-1:0] v;
        v = '0;
        for (int mm = 0; mm < NUM_MASTERS; mm++)
            v[2 * mm + 1] = 1'b1;
        return v;
    endfunction

    localparam logic [REG_W-1:0] MASK = impl_mask();

    logic [ADDR_W-1:0] off;
    logic              hit;
    logic [IDX_W-1:0]  idx;

    assign off = cfg_addr - BASE;
    assign hit = (cfg_addr >= BASE) && (off < SPAN) && (off[1:0] == 2'b00);
    assign idx = off[IDX_W+1:2];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [REG_W-1:0] RST_VAL = (i == 0) ? dom0_reset() : '0;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                table_q[i] <= RST_VAL;
            else if (cfg_wr && hit && (idx == IDX_W'(i)))
                table_q[i] <= cfg_wdata & MASK;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (hit)
            cfg_rdata = table_q[idx];
    end

    // An address outside the table must never read back anything but zero.
    assert_miss_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (cfg_rdata == '0));
endmodule

// File: rtl/perm_lookup.sv
module perm_lookup #(
    parameter int NUM_DOMAINS = 16,
    parameter int NUM_MASTERS = 6,
    parameter int REG_W       = 32,
    parameter int DOM_W       = 4,
    parameter int MST_W       = 3
) (
    input  logic [NUM_DOMAINS/2-1:0][REG_W-1:0] table_q,
    input  logic [DOM_W-1:0]                    domain,
    input  logic [MST_W-1:0]                    master,
    input  logic                                is_write,
    output logic                                allow
);
    localparam int SLOT_W = REG_W / perm_pkg::DOMS_PER_REG;
    localparam int BPOS_W = $clog2(REG_W);

    logic [REG_W-1:0]  word;
    logic [BPOS_W-1:0] bpos;
    logic              known;

    assign word  = table_q[domain[DOM_W-1:1]];
    assign bpos  = BPOS_W'(int'(domain[0]) * SLOT_W + 2 * int'(master) + int'(is_write));
    assign known = (int'(master) < NUM_MASTERS);
    assign allow = known && !word[bpos];
endmodule

// File: rtl/perm_domain_checker.sv
module perm_domain_checker #(
    parameter int NUM_DOMAINS = 16,
    parameter int NUM_MASTERS = 6,
    parameter int REG_W       = 32,
    parameter int ADDR_W      = 12,
    parameter int BASE_ADDR   = 'hB0,
    parameter int DOM_W       = $clog2(NUM_DOMAINS),
    parameter int MST_W       = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [REG_W-1:0]       cfg_wdata,
    output logic [REG_W-1:0]       cfg_rdata,
    input  logic                   acc_valid,
    input  logic [DOM_W-1:0]       acc_domain,
    input  logic [MST_W-1:0]       acc_master,
    input  logic                   acc_write,
    output logic                   res_valid,
    output logic                   res_grant,
    output logic [NUM_MASTERS-1:0] res_viol
);
    import perm_pkg::*;

    logic [NUM_DOMAINS/2-1:0][REG_W-1:0] table_q;
    logic                                allow;
    res_state_e                          state_q, state_d;
    logic [MST_W-1:0]                    mst_q;

    perm_table #(
        .NUM_DOMAINS(NUM_DOMAINS), .NUM_MASTERS(NUM_MASTERS), .REG_W(REG_W),
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .table_q(table_q)
    );

    perm_lookup #(
        .NUM_DOMAINS(NUM_DOMAINS), .NUM_MASTERS(NUM_MASTERS), .REG_W(REG_W),
        .DOM_W(DOM_W), .MST_W(MST_W)
    ) u_lookup (
        .table_q(table_q), .domain(acc_domain), .master(acc_master),
        .is_write(acc_write), .allow(allow)
    );

    always_comb begin
        unique case (state_q)
            RES_IDLE, RES_GRANT, RES_DENY:
                state_d = !acc_valid ? RES_IDLE : (allow ? RES_GRANT : RES_DENY);
            default: state_d = RES_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RES_IDLE;
            mst_q   <= '0;
        end else begin
            state_q <= state_d;
            if (acc_valid)
                mst_q <= acc_master;
        end
    end

    always_comb begin
        res_valid = 1'b0;
        res_grant = 1'b0;
        res_viol  = '0;
        unique case (state_q)
            RES_IDLE: ;
            RES_GRANT: begin
                res_valid = 1'b1;
                res_grant = 1'b1;
            end
            RES_DENY: begin
                res_valid = 1'b1;
                for (int m = 0; m < NUM_MASTERS; m++)
                    res_viol[m] = (int'(mst_q) == m);
            end
            default: ;
        endcase
    end

    assert_valid_follows_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid);
    assert_no_spurious_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid);
    assert_grant_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_grant |-> res_valid);
    assert_viol_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(res_viol));
    assert_viol_only_on_deny_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_viol != '0) |-> (res_valid && !res_grant));
    assert_deny_flags_master_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && int'(acc_master) < NUM_MASTERS) |=>
            (res_grant || res_viol != '0));
    assert_unknown_master_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && int'(acc_master) >= NUM_MASTERS) |=>
            (!res_grant && res_viol == '0));
endmodule

// File: tb/perm_domain_checker_test.sv
module perm_domain_checker_test;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [3:0]  acc_domain = '0;
    logic [2:0]  acc_master = '0;
    logic        acc_write = 1'b0;
    logic        res_valid, res_grant;
    logic [5:0]  res_viol;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    perm_domain_checker uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
        .acc_domain(acc_domain), .acc_master(acc_master), .acc_write(acc_write),
        .res_valid(res_valid), .res_grant(res_grant), .res_viol(res_viol)
    );

    function automatic logic [31:0] mask32();
        logic [31:0] m = '0;
        for (int b = 0; b < 32; b++) m[b] = ((b % 16) < 12);
        return m;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(cfg_rdata === exp, tag, cfg_rdata, exp);
    endtask

    function automatic void expect_acc(input int d, input int m, input logic w,
                                       output logic g, output logic [5:0] v);
        logic deny;
        if (m >= 6) deny = 1'b1;
        else deny = model[d/2][(d%2)*16 + 2*m + int'(w)];
        g = !deny;
        v = (deny && m < 6) ? 6'(1 << m) : 6'd0;
    endfunction

    task automatic access_chk(input int d, input int m, input logic w, input string tag);
        logic g; logic [5:0] v;
        expect_acc(d, m, w, g, v);
        @(negedge clk);
        acc_valid = 1'b1; acc_domain = 4'(d); acc_master = 3'(m); acc_write = w;
        @(negedge clk);
        acc_valid = 1'b0;
        chk(res_valid === 1'b1, {tag, " R5 valid"}, 32'(res_valid), 32'd1);
        chk(res_grant === g, {tag, " R4 grant"}, 32'(res_grant), 32'(g));
        chk(res_viol === v, {tag, " R6 viol"}, 32'(res_viol), 32'(v));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = '0;
        model[0] = 32'h0000_0AAA;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents; R5: no result without a strobe
        chk(res_valid === 1'b0 && res_viol === 6'd0, "R5 idle after reset", 32'(res_valid), 0);
        for (int i = 0; i < NREG; i++)
            cfg_read_chk(12'(32'hB0 + 4*i), model[i], "R1 reset value");

        // R8: default domain read-only for every master
        for (int m = 0; m < 6; m++) begin
            access_chk(0, m, 1'b0, "R8 dom0 read");
            access_chk(0, m, 1'b1, "R8 dom0 write");
        end

        // R2/R3: program every register with a computed pattern, check masking
        for (int i = 0; i < NREG; i++) begin
            logic [31:0] p = (32'h9E37_79B9 * (i + 1)) ^ (32'h0F0F_F0F0 >> i);
            cfg_write(12'(32'hB0 + 4*i), p);
            model[i] = p & mask32();
            cfg_read_chk(12'(32'hB0 + 4*i), model[i], "R3 unused bits zero");
        end

        // R2/R4/R6/R7: exhaustive sweep of domain x master x direction
        for (int d = 0; d < 16; d++)
            for (int m = 0; m < 8; m++)
                for (int w = 0; w < 2; w++)
                    access_chk(d, m, w[0], (m >= 6) ? "R7 sweep" : "R2 sweep");

        // R3: misaligned and out-of-range writes ignored, reads of them zero
        cfg_write(12'hB1, 32'hFFFF_FFFF);
        cfg_write(12'hD0, 32'hFFFF_FFFF);
        cfg_write(12'hAC, 32'hFFFF_FFFF);
        cfg_write(12'h8B0, 32'hFFFF_FFFF);
        for (int i = 0; i < NREG; i++)
            cfg_read_chk(12'(32'hB0 + 4*i), model[i], "R3 ignored write");
        cfg_read_chk(12'hB2, 32'd0, "R3 misaligned read");
        cfg_read_chk(12'hD0, 32'd0, "R3 out-of-range read");

        // R2: single-bit placement, domain 5 master 4 write-deny only
        cfg_write(12'hB8, 32'h0001_0000 << 9);
        model[2] = 32'h0200_0000;
        access_chk(5, 4, 1'b1, "R2 bit 25 write deny");
        access_chk(5, 4, 1'b0, "R2 bit 24 read grant");
        access_chk(4, 4, 1'b1, "R2 other slot grant");

        // R9: write and access in the same cycle use the old table
        cfg_write(12'hB4, 32'h0000_0003);
        model[1] = 32'h0000_0003;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 12'hB4; cfg_wdata = 32'd0;
        acc_valid = 1'b1; acc_domain = 4'd2; acc_master = 3'd0; acc_write = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0; acc_valid = 1'b0;
        chk(res_grant === 1'b0 && res_viol === 6'b000001, "R9 old contents used",
            {26'd0, res_viol}, 32'h1);
        model[1] = '0;
        access_chk(2, 0, 1'b0, "R9 new contents");

        // R5: back-to-back strobes then idle
        @(negedge clk);
        acc_valid = 1'b1; acc_domain = 4'd1; acc_master = 3'd1; acc_write = 1'b0;
        @(negedge clk);
        chk(res_valid === 1'b1, "R5 first of pair", 32'(res_valid), 1);
        @(negedge clk);
        acc_valid = 1'b0;
        chk(res_valid === 1'b1, "R5 second of pair", 32'(res_valid), 1);
        @(negedge clk);
        chk(res_valid === 1'b0 && res_grant === 1'b0 && res_viol === 6'd0,
            "R6 idle outputs", {26'd0, res_viol}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule